// File: doc/BRIEF.md
# Host Handshake Status Register

This block produces the read-only status byte for a peripheral that exchanges commands, execution data and results with a host through one byte-wide data port. It watches the host's data port read and write strobes and the phase reported by the command sequencer. From these it keeps a ready-for-transfer flag, a transfer direction flag, a flag for programmed-I/O execution, a command-busy flag and one seeking flag for each drive. The status byte is driven from registers and the phase inputs at all times, so the host can poll it in any cycle, including the one right after a data transfer.

The sequencer gives the number of command bytes and result bytes for the current command, whether execution uses DMA, the execution transfer direction, and whether the command is a seek-type command or a sense-interrupt command, each with a drive number. The block counts command and result bytes itself. This fixes the exact byte at which busy and the seeking flags change.

Top module: `hst_status_top`

## Requirements
- R1: After reset, with phase idle, the status byte reads 0x80: ready set, every other bit clear.
- R2: Bit 7 (ready) clears on the clock edge that takes a data port read or write. It sets again exactly LAT clocks after that edge if no further transfer arrives.
- R3: Bit 6 (direction) is 0 in the idle (phase code 0) and command (code 1) phases and 1 in the result phase (code 3). In the execution phase (code 2) it follows the execution transfer direction input (1 = toward the host).
- R4: Bit 5 is 1 only in the execution phase with DMA mode low. In the execution phase with DMA mode high, bit 7 reads 0.
- R5: Bit 4 (busy) sets after the first command byte is written, when the command has more than one byte. It stays set through the execution phase.
- R6: Busy clears after the result byte whose position equals the result count is read in the result phase. Earlier result reads leave it set.
- R7: When the result count is 0, busy clears after the last command byte is written. A one-byte command with no results never shows busy.
- R8: Bit d of bits 3..0 sets after the last command byte of a seek-type command for drive d is written. Earlier bytes of that command leave bits 3..0 unchanged.
- R9: Bit d of bits 3..0 clears after the first result byte of a sense-interrupt command for drive d is read. Other drives' bits and later result reads leave bits 3..0 unchanged.
- R10: Data port reads in the execution phase are not counted as result bytes and leave busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| dat_wr_i | input | 1 | One-cycle pulse: host wrote the data port |
| dat_rd_i | input | 1 | One-cycle pulse: host read the data port |
| phase_i | input | 2 | Sequencer phase: 0 idle, 1 command, 2 execution, 3 result |
| cmd_len_i | input | CNT_W | Command byte count of the current command (at least 1) |
| res_len_i | input | CNT_W | Result byte count of the current command (0 = none) |
| dma_mode_i | input | 1 | Execution data moves by DMA |
| xfer_to_host_i | input | 1 | Execution data flows toward the host |
| seek_cmd_i | input | 1 | Current command is seek-type |
| seek_drv_i | input | DRV_W | Drive addressed by the seek-type command |
| sense_cmd_i | input | 1 | Current command is sense-interrupt |
| sense_drv_i | input | DRV_W | Drive reported by the sense-interrupt command |
| status_o | output | 8 | Status byte |

## Verification
The properties assume a well-behaved host and sequencer. The host strobes the data port only while ready is shown and never reads and writes in the same cycle. The phase input moves idle, command, execution, result in step with the byte counts, and every drive number is below NDRV. The stimulus waits for bit 7 before each transfer and sets phase, counts and command flags only between transfers. It never transfers during DMA execution. Under these conditions every change of busy or a seeking flag can be traced to the strobe in the preceding cycle.

// File: rtl/hst_pkg.sv
package hst_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CMD  = 2'd1,
      PH_EXEC = 2'd2,
      PH_RES  = 2'd3
   } hst_phase_e;

   localparam int unsigned STAT_W    = 8;
   localparam int unsigned BIT_READY = 7;
   localparam int unsigned BIT_DIR   = 6;
   localparam int unsigned BIT_PIO   = 5;
   localparam int unsigned BIT_BUSY  = 4;
   localparam int unsigned SEEK_MAX  = 4;

endpackage

// File: rtl/hst_rqm_timer.sv
module hst_rqm_timer #(
   parameter int unsigned LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xfer_i,
   output logic rdy_o
);
   localparam int unsigned LW = (LAT > 1) ? $clog2(LAT) : 1;

   if (LAT < 1) begin : g_bad_lat
      $error("hst_rqm_timer: LAT must be at least 1");
   end

   logic rdy_q;

   if (LAT == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdy_q <= 1'b1;
         else        rdy_q <= ~xfer_i;
      end
   end else begin : g_count
      logic [LW-1:0] wait_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdy_q  <= 1'b1;
            wait_q <= '0;
         end else if (xfer_i) begin
            rdy_q  <= 1'b0;
            wait_q <= LW'(LAT - 1);
         end else if (!rdy_q) begin
            if (wait_q == '0) rdy_q <= 1'b1;
            else              wait_q <= wait_q - 1'b1;
         end
      end
   end

   assign rdy_o = rdy_q;

endmodule

// File: rtl/hst_busy_track.sv
module hst_busy_track
   import hst_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             rd_i,
   input  hst_phase_e       phase_i,
   input  logic [CNT_W-1:0] cmd_len_i,
   input  logic [CNT_W-1:0] res_len_i,
   output logic             busy_o,
   output logic             cmd_last_o,
   output logic             res_first_o
);
   if (CNT_W < 1) begin : g_bad_w
      $error("hst_busy_track: CNT_W must be at least 1");
   end

   logic             busy_q;
   logic             in_cmd_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmd_pos;
   logic [CNT_W-1:0] res_pos;
   logic             cmd_wr;
   logic             res_rd;
   logic             cmd_last;
   logic             res_last;

   // command bytes arrive in idle or command phase; a new command only
   // starts while idle, further bytes only while inside a command
   assign cmd_wr   = wr_i && (phase_i == PH_IDLE || phase_i == PH_CMD)
                     && (!busy_q || in_cmd_q);
   assign cmd_pos  = (in_cmd_q ? cnt_q : '0) + 1'b1;
   assign cmd_last = cmd_wr && (cmd_pos >= cmd_len_i);

   assign res_rd   = rd_i && (phase_i == PH_RES) && busy_q && !in_cmd_q;
   assign res_pos  = cnt_q + 1'b1;
   assign res_last = res_rd && (res_pos == res_len_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         in_cmd_q <= 1'b0;
         cnt_q    <= '0;
      end else if (cmd_wr) begin
         if (cmd_last) begin
            busy_q   <= (res_len_i != '0);
            in_cmd_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            busy_q   <= 1'b1;
            in_cmd_q <= 1'b1;
            cnt_q    <= cmd_pos;
         end
      end else if (res_rd) begin
         if (res_last) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= res_pos;
         end
      end
   end

   assign busy_o      = busy_q;
   assign cmd_last_o  = cmd_last;
   assign res_first_o = res_rd && (cnt_q == '0);

endmodule

// File: rtl/hst_seek_flags.sv
module hst_seek_flags #(
   parameter int unsigned NDRV  = 4,
   parameter int unsigned DRV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [DRV_W-1:0] set_drv_i,
   input  logic             clr_i,
   input  logic [DRV_W-1:0] clr_drv_i,
   output logic [NDRV-1:0]  flags_o
);
   for (genvar d = 0; d < NDRV; d++) begin : g_drv
      logic hit_set;
      logic hit_clr;
      logic flag_q;
      assign hit_set = set_i && (set_drv_i == DRV_W'(d));
      assign hit_clr = clr_i && (clr_drv_i == DRV_W'(d));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flag_q <= 1'b0;
         else if (hit_set) flag_q <= 1'b1;
         else if (hit_clr) flag_q <= 1'b0;
      end
      assign flags_o[d] = flag_q;
   end

endmodule

// File: rtl/hst_status_top.sv
module hst_status_top
   import hst_pkg::*;
#(
   parameter int unsigned NDRV  = 4,
   parameter int unsigned LAT   = 3,
   parameter int unsigned CNT_W = 4,
   localparam int unsigned DRV_W = (NDRV > 1) ? $clog2(NDRV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dat_wr_i,
   input  logic             dat_rd_i,
   input  logic [1:0]       phase_i,
   input  logic [CNT_W-1:0] cmd_len_i,
   input  logic [CNT_W-1:0] res_len_i,
   input  logic             dma_mode_i,
   input  logic             xfer_to_host_i,
   input  logic             seek_cmd_i,
   input  logic [DRV_W-1:0] seek_drv_i,
   input  logic             sense_cmd_i,
   input  logic [DRV_W-1:0] sense_drv_i,
   output logic [7:0]       status_o
);
   if (NDRV < 1 || NDRV > SEEK_MAX) begin : g_bad_ndrv
      $error("hst_status_top: NDRV must be 1..4");
   end

   hst_phase_e      phase;
   logic            rqm_q;
   logic            busy;
   logic            cmd_last;
   logic            res_first;
   logic [NDRV-1:0] seek_flags;
   logic [SEEK_MAX-1:0] seek_field;
   logic            exec_ph;

   assign phase   = hst_phase_e'(phase_i);
   assign exec_ph = (phase == PH_EXEC);

   hst_rqm_timer #(.LAT(LAT)) u_rqm (
      .clk    (clk),
      .rst_n  (rst_n),
      .xfer_i (dat_wr_i | dat_rd_i),
      .rdy_o  (rqm_q)
   );

   hst_busy_track #(.CNT_W(CNT_W)) u_busy (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (dat_wr_i),
      .rd_i        (dat_rd_i),
      .phase_i     (phase),
      .cmd_len_i   (cmd_len_i),
      .res_len_i   (res_len_i),
      .busy_o      (busy),
      .cmd_last_o  (cmd_last),
      .res_first_o (res_first)
   );

   hst_seek_flags #(.NDRV(NDRV), .DRV_W(DRV_W)) u_seek (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (cmd_last && seek_cmd_i),
      .set_drv_i (seek_drv_i),
      .clr_i     (res_first && sense_cmd_i),
      .clr_drv_i (sense_drv_i),
      .flags_o   (seek_flags)
   );

   if (NDRV < SEEK_MAX) begin : g_pad
      assign seek_field = {{(SEEK_MAX-NDRV){1'b0}}, seek_flags};
   end else begin : g_full
      assign seek_field = seek_flags;
   end

   always_comb begin
      status_o            = '0;
      status_o[BIT_READY] = rqm_q && !(exec_ph && dma_mode_i);
      status_o[BIT_DIR]   = (phase == PH_RES) || (exec_ph && xfer_to_host_i);
      status_o[BIT_PIO]   = exec_ph && !dma_mode_i;
      status_o[BIT_BUSY]  = busy;
      status_o[SEEK_MAX-1:0] = seek_field;
   end

endmodule

// File: rtl/hst_status_chk.sv
module hst_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dat_wr_i,
   input logic       dat_rd_i,
   input logic [1:0] phase_i,
   input logic       dma_mode_i,
   input logic       seek_cmd_i,
   input logic       sense_cmd_i,
   input logic       rqm_q,
   input logic [7:0] status_o
);
   // R2
   xfer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr_i || dat_rd_i) |=> !rqm_q);

   // R2
   rqm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rqm_q) |-> !$past(dat_wr_i || dat_rd_i));

   // R4
   pio_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[5] |-> (phase_i == 2'd2));

   // R4
   dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == 2'd2 && dma_mode_i) |-> !status_o[7]);

   // R5
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[4]) |-> $past(dat_wr_i));

   // R6
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[4]) |-> $past(dat_wr_i || (dat_rd_i && phase_i == 2'd3)));

   // R8
   seek_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status_o[3:0] & ~$past(status_o[3:0]))) |-> $past(dat_wr_i && seek_cmd_i));

   // R9
   seek_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~status_o[3:0] & $past(status_o[3:0])))
         |-> $past(dat_rd_i && sense_cmd_i && phase_i == 2'd3));

endmodule

bind hst_status_top hst_status_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dat_wr_i    (dat_wr_i),
   .dat_rd_i    (dat_rd_i),
   .phase_i     (phase_i),
   .dma_mode_i  (dma_mode_i),
   .seek_cmd_i  (seek_cmd_i),
   .sense_cmd_i (sense_cmd_i),
   .rqm_q       (rqm_q),
   .status_o    (status_o)
);

// File: tb/sim_hst_status_top.sv
module sim_hst_status_top;
   localparam int unsigned NDRV  = 4;
   localparam int unsigned LAT   = 3;
   localparam int unsigned CNT_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             dat_wr_i = 1'b0;
   logic             dat_rd_i = 1'b0;
   logic [1:0]       phase_i = 2'd0;
   logic [CNT_W-1:0] cmd_len_i = 4'd1;
   logic [CNT_W-1:0] res_len_i = 4'd0;
   logic             dma_mode_i = 1'b0;
   logic             xfer_to_host_i = 1'b0;
   logic             seek_cmd_i = 1'b0;
   logic [1:0]       seek_drv_i = 2'd0;
   logic             sense_cmd_i = 1'b0;
   logic [1:0]       sense_drv_i = 2'd0;
   logic [7:0]       status_o;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   hst_status_top #(.NDRV(NDRV), .LAT(LAT), .CNT_W(CNT_W)) u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .dat_wr_i       (dat_wr_i),
      .dat_rd_i       (dat_rd_i),
      .phase_i        (phase_i),
      .cmd_len_i      (cmd_len_i),
      .res_len_i      (res_len_i),
      .dma_mode_i     (dma_mode_i),
      .xfer_to_host_i (xfer_to_host_i),
      .seek_cmd_i     (seek_cmd_i),
      .seek_drv_i     (seek_drv_i),
      .sense_cmd_i    (sense_cmd_i),
      .sense_drv_i    (sense_drv_i),
      .status_o       (status_o)
   );

   task automatic check(input string tag, input logic [7:0] mask, input logic [7:0] exp);
      total++;
      if ((status_o & mask) !== (exp & mask)) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h (mask %02h)",
                  tag, status_o & mask, exp & mask, mask);
      end
   endtask

   task automatic wait_ready();
      for (int k = 0; k < 40 && !status_o[7]; k++) @(negedge clk);
   endtask

   task automatic host_wr();
      wait_ready();
      dat_wr_i = 1'b1;
      @(negedge clk);
      dat_wr_i = 1'b0;
   endtask

   task automatic host_rd();
      wait_ready();
      dat_rd_i = 1'b1;
      @(negedge clk);
      dat_rd_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 reset status", 8'hFF, 8'h80);
   endtask

   // three-byte command, two results, programmed-I/O execution
   task automatic t_full_cmd();
      cmd_len_i = 4'd3; res_len_i = 4'd2; phase_i = 2'd0;
      host_wr();
      check("R2 ready drops after write", 8'h80, 8'h00);
      check("R5 busy after first byte", 8'h10, 8'h10);
      phase_i = 2'd1;
      check("R3 dir in command phase", 8'h40, 8'h00);
      repeat (LAT-1) @(negedge clk);
      check("R2 ready still low before LAT", 8'h80, 8'h00);
      @(negedge clk);
      check("R2 ready back after LAT", 8'h80, 8'h80);
      host_wr();
      host_wr();
      check("R5 busy after last command byte", 8'h10, 8'h10);
      phase_i = 2'd2; dma_mode_i = 1'b0; xfer_to_host_i = 1'b1;
      @(negedge clk);
      check("R4 pio bit in execution", 8'h20, 8'h20);
      check("R3 dir follows exec direction", 8'h40, 8'h40);
      host_rd();
      host_rd();
      check("R10 exec reads keep busy", 8'h10, 8'h10);
      xfer_to_host_i = 1'b0;
      @(negedge clk);
      check("R3 dir exec toward core", 8'h40, 8'h00);
      dma_mode_i = 1'b1;
      @(negedge clk);
      check("R4 dma execution hides ready and pio", 8'hA0, 8'h00);
      dma_mode_i = 1'b0; phase_i = 2'd3;
      @(negedge clk);
      check("R3 dir in result phase", 8'h60, 8'h40);
      host_rd();
      check("R6 busy held after first result", 8'h10, 8'h10);
      host_rd();
      check("R6 busy clear after last result", 8'h10, 8'h00);
      phase_i = 2'd0;
      @(negedge clk);
      check("R3 dir idle", 8'h40, 8'h00);
   endtask

   task automatic t_no_result();
      cmd_len_i = 4'd2; res_len_i = 4'd0; phase_i = 2'd0;
      host_wr();
      check("R5 busy after first byte (no results)", 8'h10, 8'h10);
      phase_i = 2'd1;
      host_wr();
      check("R7 busy clear after last command byte", 8'h10, 8'h00);
      phase_i = 2'd0; cmd_len_i = 4'd1;
      host_wr();
      check("R7 single byte command never busy", 8'h10, 8'h00);
   endtask

   task automatic t_seek();
      cmd_len_i = 4'd3; res_len_i = 4'd0; seek_cmd_i = 1'b1; seek_drv_i = 2'd2;
      phase_i = 2'd0;
      host_wr();
      phase_i = 2'd1;
      host_wr();
      check("R8 no seek flag before last byte", 8'h0F, 8'h00);
      host_wr();
      check("R8 drive 2 seeking", 8'h0F, 8'h04);
      phase_i = 2'd0; cmd_len_i = 4'd2; seek_drv_i = 2'd0;
      host_wr();
      phase_i = 2'd1;
      host_wr();
      check("R8 drive 0 seeking too", 8'h0F, 8'h05);
      seek_cmd_i = 1'b0; phase_i = 2'd0;
   endtask

   task automatic t_sense();
      cmd_len_i = 4'd2; res_len_i = 4'd2; sense_cmd_i = 1'b1; sense_drv_i = 2'd2;
      phase_i = 2'd0;
      host_wr();
      phase_i = 2'd1;
      host_wr();
      check("R9 flags kept through sense command bytes", 8'h0F, 8'h05);
      phase_i = 2'd3;
      host_rd();
      check("R9 drive 2 cleared on first result", 8'h1F, 8'h11);
      sense_drv_i = 2'd0;
      host_rd();
      check("R9 later result leaves flags", 8'h1F, 8'h01);
      sense_cmd_i = 1'b0; phase_i = 2'd0;
   endtask

   initial begin : watchdog
      #(20 * 100000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_cmd();
      t_no_result();
      t_seek();
      t_sense();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule